// File: doc/BRIEF.md
# Two-Wire Thermal Register Slave

This block is the serial front end of a thermal monitor. It is a slave on a two-wire (I2C/SMBus) bus and exposes a small bank of 16-bit registers through an 8-bit pointer. A host first writes the pointer. It can then write one data word, or read the word the pointer selects. Data moves most significant byte first, and within each byte the most significant bit first. The pointer keeps its value across transactions. Repeated reads of the same register therefore need only the address byte.

The bank holds configuration, three trip thresholds (upper, lower, critical), a timeout-control word, and constant identification words. It also presents a live temperature word supplied by the sensing logic. The configuration and trip values leave the block as registered outputs for the comparison logic next to it.

A watchdog on the clock line returns the protocol engine to idle when SCL stays low too long. Software can switch this watchdog off.

Top module: `thermo_reg_slave`

## Requirements
- R1: After reset, SDA is released (`sda_oe`=0), configuration, all trip values and timeout control read 0000h, and the pointer selects location 00h.
- R2: The slave answers only the 7-bit address {`ADDR_HI`, `addr_sel`} (default high nibble 0011b) by pulling SDA low in the acknowledge slot. Any other address gets no acknowledge and changes nothing.
- R3: Register map: 00h capability (reads `CAP_VALUE`, default 006Fh), 01h configuration, 02h upper trip, 03h lower trip, 04h critical trip, 05h temperature, 06h manufacturer, 07h device, 22h timeout control. The pointer keeps the last value written. A read without a pointer byte returns the register at the stored pointer.
- R4: A write is address with R/W=0, then the pointer byte, then the high data byte, then the low data byte. The slave acknowledges each of these bytes. The written word appears on the matching output port.
- R5: A read with R/W=1 returns the high byte, then the low byte. A master NACK ends the transfer, and the slave releases SDA.
- R6: Location 06h reads 1131h. Location 07h reads A102h.
- R7: Location 05h reads the `temp_in` value present when the read data is loaded.
- R8: Reserved bits are discarded on write and read as zero. Trip registers keep bits 12:2. Configuration keeps bits 10:0. Timeout control keeps only bit 7.
- R9: Writes to read-only locations (00h, 05h, 06h, 07h) are acknowledged and have no effect.
- R10: When configuration bit 7 is 1, writes to the critical trip are ignored. When configuration bit 6 is 1, writes to the upper and lower trips are ignored.
- R11: When SCL stays low for `TIMEOUT_CYCLES` clocks, the engine returns to idle and releases SDA.
- R12: Writing 1 to bit 7 of location 22h disables the SCL-low timeout.
- R13: A repeated START in any state restarts address reception.
- R14: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain drive) |
| addr_sel | input | 3 | Strapped low address bits |
| temp_in | input | 16 | Live temperature word |
| cfg_word | output | 16 | Configuration register |
| upper_trip | output | 16 | Upper threshold |
| lower_trip | output | 16 | Lower threshold |
| crit_trip | output | 16 | Critical threshold |

## Verification
The bench builds the block with `TIMEOUT_CYCLES` set to 400 and a bit time of 40 clocks. No bit of normal traffic holds SCL low long enough to trip the watchdog. A deliberate stall in the acknowledge slot, however, expires it within a few hundred cycles. This makes the timeout, its recovery and its software disable all checkable within a short run. The strap value 101b puts a neighbouring address one step away, which exercises the address compare.

// File: rtl/trs_pkg.sv
package trs_pkg;
  localparam logic [7:0] PTR_CAP   = 8'h00;
  localparam logic [7:0] PTR_CFG   = 8'h01;
  localparam logic [7:0] PTR_UPPER = 8'h02;
  localparam logic [7:0] PTR_LOWER = 8'h03;
  localparam logic [7:0] PTR_CRIT  = 8'h04;
  localparam logic [7:0] PTR_TEMP  = 8'h05;
  localparam logic [7:0] PTR_MFG   = 8'h06;
  localparam logic [7:0] PTR_DEV   = 8'h07;
  localparam logic [7:0] PTR_TMO   = 8'h22;

  localparam logic [15:0] CFG_KEEP  = 16'h07FF;
  localparam logic [15:0] TRIP_KEEP = 16'h1FFC;
  localparam logic [15:0] TMO_KEEP  = 16'h0080;

  localparam int CFG_CRIT_LOCK = 7;
  localparam int CFG_WIN_LOCK  = 6;
  localparam int TMO_OFF_BIT   = 7;

  typedef enum logic [2:0] {BS_IDLE, BS_RX, BS_ACK, BS_TX, BS_MACK, BS_SKIP} bus_state_t;
  typedef enum logic [1:0] {RX_ADDR, RX_PTR, RX_MSB, RX_LSB} rx_kind_t;
endpackage

// File: rtl/trs_scl_watch.sv
module trs_scl_watch #(
  parameter int LIMIT = 3000000
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_low,
  input  logic enable,
  output logic fire
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM    = CW'(LIMIT);
  localparam logic [CW-1:0] LIM_M1 = CW'(LIMIT - 1);

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst || !scl_low || !enable) low_cnt <= '0;
    else if (low_cnt != LIM)        low_cnt <= low_cnt + 1'b1;
  end

  assign fire = enable && scl_low && (low_cnt == LIM_M1);
endmodule

// File: rtl/trs_regbank.sv
module trs_regbank import trs_pkg::*; #(
  parameter logic [15:0] CAP_VALUE = 16'h006F,
  parameter logic [15:0] MFG_ID    = 16'h1131,
  parameter logic [15:0] DEV_ID    = 16'hA102
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [7:0]  ptr,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  input  logic [15:0] temp_in,
  output logic [15:0] rd_data,
  output logic [15:0] cfg_q,
  output logic [15:0] upper_q,
  output logic [15:0] lower_q,
  output logic [15:0] crit_q,
  output logic        tmo_off
);
  logic [15:0] tmo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= '0;
      upper_q <= '0;
      lower_q <= '0;
      crit_q  <= '0;
      tmo_q   <= '0;
    end else if (wr_en) begin
      case (ptr)
        PTR_CFG:   cfg_q <= wr_data & CFG_KEEP;
        PTR_UPPER: if (!cfg_q[CFG_WIN_LOCK])  upper_q <= wr_data & TRIP_KEEP;
        PTR_LOWER: if (!cfg_q[CFG_WIN_LOCK])  lower_q <= wr_data & TRIP_KEEP;
        PTR_CRIT:  if (!cfg_q[CFG_CRIT_LOCK]) crit_q  <= wr_data & TRIP_KEEP;
        PTR_TMO:   tmo_q <= wr_data & TMO_KEEP;
        default:   ;
      endcase
    end
  end

  always_comb begin
    case (ptr)
      PTR_CAP:   rd_data = CAP_VALUE;
      PTR_CFG:   rd_data = cfg_q;
      PTR_UPPER: rd_data = upper_q;
      PTR_LOWER: rd_data = lower_q;
      PTR_CRIT:  rd_data = crit_q;
      PTR_TEMP:  rd_data = temp_in;
      PTR_MFG:   rd_data = MFG_ID;
      PTR_DEV:   rd_data = DEV_ID;
      PTR_TMO:   rd_data = tmo_q;
      default:   rd_data = '0;
    endcase
  end

  assign tmo_off = tmo_q[TMO_OFF_BIT];
endmodule

// File: rtl/trs_bus_fsm.sv
module trs_bus_fsm import trs_pkg::*; #(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] dev_addr,
  input  logic              tmo_fire,
  input  logic [15:0]       rd_data,
  output logic [7:0]        ptr,
  output logic              wr_en,
  output logic [15:0]       wr_data,
  output logic              sda_oe,
  output logic              scl_low
);
  logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
  logic scl_s, sda_s, scl_q, sda_q;
  logic scl_rise, scl_fall, start_ev, stop_ev;

  bus_state_t  state, after_ack;
  rx_kind_t    rx_kind;
  logic [3:0]  cnt;
  logic [7:0]  shreg, msb_hold;
  logic [15:0] tx;
  logic        lo_byte, m_nack;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
      sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end
  end

  assign scl_s    = scl_sync[SYNC_STAGES-1];
  assign sda_s    = sda_sync[SYNC_STAGES-1];
  assign scl_rise = scl_s && !scl_q;
  assign scl_fall = !scl_s && scl_q;
  assign start_ev = scl_s && scl_q && sda_q && !sda_s;
  assign stop_ev  = scl_s && scl_q && !sda_q && sda_s;
  assign scl_low  = !scl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= BS_IDLE;
      after_ack <= BS_IDLE;
      rx_kind   <= RX_ADDR;
      cnt       <= '0;
      shreg     <= '0;
      msb_hold  <= '0;
      tx        <= '0;
      lo_byte   <= 1'b0;
      m_nack    <= 1'b0;
      ptr       <= PTR_CAP;
      wr_en     <= 1'b0;
      wr_data   <= '0;
      sda_oe    <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (tmo_fire || stop_ev) begin
        state  <= BS_IDLE;
        sda_oe <= 1'b0;
      end else if (start_ev) begin
        state   <= BS_RX;
        rx_kind <= RX_ADDR;
        cnt     <= '0;
        sda_oe  <= 1'b0;
      end else begin
        case (state)
          BS_RX: begin
            if (scl_rise) begin
              shreg <= {shreg[6:0], sda_s};
              cnt   <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              cnt    <= '0;
              sda_oe <= 1'b1;
              state  <= BS_ACK;
              case (rx_kind)
                RX_ADDR: begin
                  if (shreg[7:1] == dev_addr) begin
                    after_ack <= shreg[0] ? BS_TX : BS_RX;
                    rx_kind   <= RX_PTR;
                  end else begin
                    sda_oe <= 1'b0;
                    state  <= BS_SKIP;
                  end
                end
                RX_PTR: begin
                  ptr       <= shreg;
                  rx_kind   <= RX_MSB;
                  after_ack <= BS_RX;
                end
                RX_MSB: begin
                  msb_hold  <= shreg;
                  rx_kind   <= RX_LSB;
                  after_ack <= BS_RX;
                end
                default: begin
                  wr_en     <= 1'b1;
                  wr_data   <= {msb_hold, shreg};
                  after_ack <= BS_SKIP;
                end
              endcase
            end
          end
          BS_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              state  <= after_ack;
              cnt    <= '0;
              if (after_ack == BS_TX) begin
                tx      <= rd_data;
                sda_oe  <= ~rd_data[15];
                lo_byte <= 1'b0;
              end
            end
          end
          BS_TX: begin
            if (scl_rise) begin
              cnt <= cnt + 4'd1;
            end else if (scl_fall) begin
              if (cnt == 4'd8) begin
                sda_oe <= 1'b0;
                state  <= BS_MACK;
              end else begin
                tx     <= {tx[14:0], 1'b0};
                sda_oe <= ~tx[14];
              end
            end
          end
          BS_MACK: begin
            if (scl_rise) begin
              m_nack <= sda_s;
            end else if (scl_fall) begin
              cnt <= '0;
              if (m_nack) begin
                state <= BS_SKIP;
              end else begin
                state <= BS_TX;
                if (lo_byte) begin
                  tx      <= rd_data;
                  sda_oe  <= ~rd_data[15];
                  lo_byte <= 1'b0;
                end else begin
                  tx      <= {tx[14:0], 1'b0};
                  sda_oe  <= ~tx[14];
                  lo_byte <= 1'b1;
                end
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/thermo_reg_slave.sv
module thermo_reg_slave #(
  parameter logic [3:0]  ADDR_HI        = 4'b0011,
  parameter int          TIMEOUT_CYCLES = 3000000,
  parameter int          SYNC_STAGES    = 2,
  parameter logic [15:0] CAP_VALUE      = 16'h006F,
  parameter logic [15:0] MFG_ID         = 16'h1131,
  parameter logic [15:0] DEV_ID         = 16'hA102
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe,
  input  logic [2:0]  addr_sel,
  input  logic [15:0] temp_in,
  output logic [15:0] cfg_word,
  output logic [15:0] upper_trip,
  output logic [15:0] lower_trip,
  output logic [15:0] crit_trip
);
  localparam int ADDR_W = 4 + 3;

  logic [ADDR_W-1:0] dev_addr;
  logic [7:0]  ptr;
  logic        wr_en, tmo_fire, tmo_off, scl_low;
  logic [15:0] wr_data, rd_data;

  assign dev_addr = {ADDR_HI, addr_sel};

  trs_bus_fsm #(.SYNC_STAGES(SYNC_STAGES), .ADDR_W(ADDR_W)) u_bus (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .dev_addr(dev_addr),
    .tmo_fire(tmo_fire), .rd_data(rd_data), .ptr(ptr), .wr_en(wr_en),
    .wr_data(wr_data), .sda_oe(sda_oe), .scl_low(scl_low)
  );

  trs_regbank #(.CAP_VALUE(CAP_VALUE), .MFG_ID(MFG_ID), .DEV_ID(DEV_ID)) u_regs (
    .clk(clk), .rst(rst), .ptr(ptr), .wr_en(wr_en), .wr_data(wr_data),
    .temp_in(temp_in), .rd_data(rd_data), .cfg_q(cfg_word), .upper_q(upper_trip),
    .lower_q(lower_trip), .crit_q(crit_trip), .tmo_off(tmo_off)
  );

  trs_scl_watch #(.LIMIT(TIMEOUT_CYCLES)) u_watch (
    .clk(clk), .rst(rst), .scl_low(scl_low), .enable(!tmo_off), .fire(tmo_fire)
  );
endmodule

// File: rtl/trs_checker.sv
module trs_checker import trs_pkg::*; #(
  parameter int TMO_CYCLES = 3000000
) (
  input logic        clk,
  input logic        rst,
  input logic        scl_i,
  input logic        sda_oe,
  input logic [15:0] cfg_word,
  input logic [15:0] upper_trip,
  input logic [15:0] lower_trip,
  input logic [15:0] crit_trip,
  input logic        tmo_off
);
  localparam int SLACK = 8;
  localparam longint CAP = longint'(TMO_CYCLES) + SLACK;

  logic [31:0] low_run;

  always_ff @(posedge clk) begin
    if (rst || scl_i)            low_run <= '0;
    else if (low_run < 32'(CAP)) low_run <= low_run + 1'b1;
  end

  // R14: drive only moves while the clock line is low
  assert_sda_moves_low_R14: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_i);

  // R10: critical threshold frozen while its lock is set
  assert_crit_locked_R10: assert property (@(posedge clk) disable iff (rst)
    $past(cfg_word[CFG_CRIT_LOCK]) |-> $stable(crit_trip));

  // R10: window thresholds frozen while their lock is set
  assert_window_locked_R10: assert property (@(posedge clk) disable iff (rst)
    $past(cfg_word[CFG_WIN_LOCK]) |-> ($stable(upper_trip) && $stable(lower_trip)));

  // R8: reserved threshold bits stay clear
  assert_rfu_clear_R8: assert property (@(posedge clk) disable iff (rst)
    ((upper_trip | lower_trip | crit_trip) & ~TRIP_KEEP) == 16'h0000);

  // R11: long clock-low stall must leave SDA released when the watchdog is on
  assert_stall_release_R11: assert property (@(posedge clk) disable iff (rst)
    (low_run >= 32'(CAP) && !tmo_off) |-> !sda_oe);
endmodule

bind thermo_reg_slave trs_checker #(.TMO_CYCLES(TIMEOUT_CYCLES)) chk_i (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_oe(sda_oe), .cfg_word(cfg_word),
  .upper_trip(upper_trip), .lower_trip(lower_trip), .crit_trip(crit_trip),
  .tmo_off(tmo_off)
);

// File: tb/thermo_reg_slave_tb_top.sv
`timescale 1ns/1ps
module thermo_reg_slave_tb_top;
  localparam int TMO = 400;
  localparam int Q   = 10;
  localparam logic [6:0] MY_ADDR    = 7'h1D;
  localparam logic [6:0] OTHER_ADDR = 7'h1C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic scl = 1'b1, sda_drv = 1'b1;
  logic [15:0] temp = 16'h0190;
  logic sda_oe, sda_line;
  logic [15:0] cfg_w, up_w, lo_w, cr_w;

  assign sda_line = sda_drv & ~sda_oe;

  thermo_reg_slave #(.TIMEOUT_CYCLES(TMO)) dut_i (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .addr_sel(3'b101), .temp_in(temp), .cfg_word(cfg_w), .upper_trip(up_w),
    .lower_trip(lo_w), .crit_trip(cr_w)
  );

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_xfer(input logic b, output logic r);
    sda_drv = b; wt(Q);
    scl = 1'b1; wt(Q);
    r = sda_line; wt(Q);
    scl = 1'b0; wt(Q);
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; wt(Q);
    scl = 1'b1; wt(Q);
    sda_drv = 1'b0; wt(Q);
    scl = 1'b0; wt(Q);
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; wt(Q);
    scl = 1'b1; wt(Q);
    sda_drv = 1'b1; wt(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack_n);
    logic r;
    for (int i = 7; i >= 0; i--) bit_xfer(b[i], r);
    bit_xfer(1'b1, ack_n);
  endtask

  task automatic recv_byte(input logic last, output logic [7:0] v);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bit_xfer(1'b1, r);
      v[i] = r;
    end
    bit_xfer(last, r);
  endtask

  task automatic reg_write(input logic [6:0] a, input logic [7:0] p, input logic [15:0] d,
                           output logic [3:0] acks);
    bus_start();
    send_byte({a, 1'b0}, acks[3]);
    send_byte(p, acks[2]);
    send_byte(d[15:8], acks[1]);
    send_byte(d[7:0], acks[0]);
    bus_stop();
  endtask

  task automatic read_cur(input logic [6:0] a, output logic [15:0] d);
    logic k;
    bus_start();
    send_byte({a, 1'b1}, k);
    recv_byte(1'b0, d[15:8]);
    recv_byte(1'b1, d[7:0]);
    bus_stop();
  endtask

  task automatic reg_read(input logic [6:0] a, input logic [7:0] p, output logic [15:0] d);
    logic k;
    bus_start();
    send_byte({a, 1'b0}, k);
    send_byte(p, k);
    bus_start();
    send_byte({a, 1'b1}, k);
    recv_byte(1'b0, d[15:8]);
    recv_byte(1'b1, d[7:0]);
    bus_stop();
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk("R1 sda released", {15'd0, sda_oe}, 16'h0000);
    chk("R1 cfg", cfg_w, 16'h0000);
    chk("R1 upper", up_w, 16'h0000);
    chk("R1 crit", cr_w, 16'h0000);
    read_cur(MY_ADDR, d);
    chk("R1 R3 pointer 00h capability", d, 16'h006F);
  endtask

  task automatic t_addr_match();
    logic [3:0] a;
    reg_write(OTHER_ADDR, 8'h02, 16'h1234, a);
    chk("R2 no ack other address", {15'd0, a[3]}, 16'h0001);
    chk("R2 other address no effect", up_w, 16'h0000);
    reg_write(MY_ADDR, 8'h02, 16'h0550, a);
    chk("R2 R4 all bytes acked", {12'd0, a}, 16'h0000);
    chk("R4 upper written", up_w, 16'h0550);
  endtask

  task automatic t_write_mask();
    logic [3:0] a;
    logic [15:0] d;
    reg_write(MY_ADDR, 8'h03, 16'hFFFF, a);
    chk("R8 lower masked", lo_w, 16'h1FFC);
    reg_read(MY_ADDR, 8'h03, d);
    chk("R5 R8 lower readback", d, 16'h1FFC);
    reg_write(MY_ADDR, 8'h04, 16'h0A5F, a);
    chk("R4 R8 crit written", cr_w, 16'h0A5C);
  endtask

  task automatic t_ids();
    logic [15:0] d;
    reg_read(MY_ADDR, 8'h06, d);
    chk("R6 manufacturer", d, 16'h1131);
    reg_read(MY_ADDR, 8'h07, d);
    chk("R6 device", d, 16'hA102);
  endtask

  task automatic t_temp();
    logic [15:0] d;
    temp = 16'h8C4A;
    reg_read(MY_ADDR, 8'h05, d);
    chk("R7 temperature", d, 16'h8C4A);
    temp = 16'h0193;
    read_cur(MY_ADDR, d);
    chk("R7 temperature follows input", d, 16'h0193);
  endtask

  task automatic t_readonly();
    logic [3:0] a;
    logic [15:0] d;
    reg_write(MY_ADDR, 8'h06, 16'h0000, a);
    chk("R9 ro write acked", {12'd0, a}, 16'h0000);
    reg_read(MY_ADDR, 8'h06, d);
    chk("R9 manufacturer unchanged", d, 16'h1131);
    reg_write(MY_ADDR, 8'h00, 16'h1111, a);
    reg_read(MY_ADDR, 8'h00, d);
    chk("R9 capability unchanged", d, 16'h006F);
  endtask

  task automatic t_lock();
    logic [3:0] a;
    reg_write(MY_ADDR, 8'h01, 16'h0080, a);
    chk("R10 cfg crit lock", cfg_w, 16'h0080);
    reg_write(MY_ADDR, 8'h04, 16'h0100, a);
    chk("R10 crit locked", cr_w, 16'h0A5C);
    reg_write(MY_ADDR, 8'h02, 16'h0200, a);
    chk("R10 upper free under crit lock", up_w, 16'h0200);
    reg_write(MY_ADDR, 8'h01, 16'h0040, a);
    reg_write(MY_ADDR, 8'h02, 16'h0300, a);
    chk("R10 upper locked", up_w, 16'h0200);
    reg_write(MY_ADDR, 8'h03, 16'h0040, a);
    chk("R10 lower locked", lo_w, 16'h1FFC);
    reg_write(MY_ADDR, 8'h04, 16'h0100, a);
    chk("R10 crit free under window lock", cr_w, 16'h0100);
    reg_write(MY_ADDR, 8'h01, 16'hFFFF, a);
    chk("R8 cfg masked", cfg_w, 16'h07FF);
    reg_write(MY_ADDR, 8'h01, 16'h0000, a);
    chk("R10 unlock", cfg_w, 16'h0000);
  endtask

  task automatic t_pointer();
    logic [15:0] d;
    reg_read(MY_ADDR, 8'h02, d);
    chk("R13 repeated start read", d, 16'h0200);
    read_cur(MY_ADDR, d);
    chk("R3 pointer persists", d, 16'h0200);
    read_cur(MY_ADDR, d);
    chk("R3 pointer persists again", d, 16'h0200);
    chk("R5 released after nack", {15'd0, sda_oe}, 16'h0000);
  endtask

  task automatic stall_in_ack();
    logic r;
    logic [7:0] b;
    b = {MY_ADDR, 1'b0};
    bus_start();
    for (int i = 7; i >= 0; i--) bit_xfer(b[i], r);
    sda_drv = 1'b1;
    wt(4);
  endtask

  task automatic t_timeout();
    logic [15:0] d;
    stall_in_ack();
    chk("R2 ack driven in stall", {15'd0, sda_oe}, 16'h0001);
    wt(TMO + 30);
    chk("R11 timeout releases sda", {15'd0, sda_oe}, 16'h0000);
    bus_stop();
    reg_read(MY_ADDR, 8'h07, d);
    chk("R11 bus usable after timeout", d, 16'hA102);
  endtask

  task automatic t_timeout_off();
    logic [3:0] a;
    logic [15:0] d;
    reg_write(MY_ADDR, 8'h22, 16'hFFFF, a);
    reg_read(MY_ADDR, 8'h22, d);
    chk("R12 R8 timeout control", d, 16'h0080);
    stall_in_ack();
    wt(TMO + 30);
    chk("R12 no timeout when disabled", {15'd0, sda_oe}, 16'h0001);
    scl = 1'b1; wt(2*Q);
    scl = 1'b0; wt(Q);
    bus_stop();
    reg_write(MY_ADDR, 8'h22, 16'h0000, a);
    reg_read(MY_ADDR, 8'h22, d);
    chk("R12 timeout re-enabled", d, 16'h0000);
  endtask

  initial begin
    wt(5);
    rst = 1'b0;
    wt(5);
    t_reset();
    t_addr_match();
    t_write_mask();
    t_ids();
    t_temp();
    t_readonly();
    t_lock();
    t_pointer();
    t_timeout();
    t_timeout_off();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule